// File: doc/BRIEF.md
# Staircase Block Encoder

This block turns a stream of information bits into a staircase-coded stream of square binary blocks. Each block has S rows and S columns, with S = 8 by default. Every new block is tied to the block before it. Row j of a new block, placed after column j of the previous block, forms one codeword of an extended Hamming code of length 2S. Each bit is therefore covered twice: once through its row in one block, and once through its column as part of the next block's codewords.

Information enters on a valid/ready stream with K = S - M - 1 bits per beat, where M = log2(2S). Each accepted beat produces one S-bit coded row on a valid/ready output stream, one cycle later. The block keeps the previous block internally. After the last row of a block is accepted, the finished block becomes the new previous block. After reset, the previous block is all zeros.

Top module: `sc_staircase_encoder`

## Requirements
- R1: Output row layout. Bits [K-1:0] repeat the accepted information bits, with in_info[b] in bit b. Bits [K+M-1:K] carry the Hamming check bits c0..cM-1, with ck in bit K+k. Bit S-1 carries the overall parity bit.
- R2: The 11 data bits (for S = 8) are the previous block's column followed by the information bits. Data bit n, for n < S, is bit j of previous-block row n. Data bit S+b is information bit b. Data bit n sits at the n-th Hamming position, counting in ascending order from 1 and skipping powers of two, so the positions are 3, 5, 6, 7, 9 and onward. Check bit ck is the XOR of the data bits whose position has bit k set.
- R3: The overall parity bit makes the XOR of all 2S codeword bits zero. The full codeword (column plus row) therefore has a zero syndrome and even weight.
- R4: The first block after reset is coupled to an all-zero previous block, so its check bits depend only on the information bits.
- R5: Row j of a block (j = 0..S-1, in acceptance order) is coded using column j of the previous block.
- R6: Once row S-1 is accepted, the finished block becomes the previous block, and the next accepted beat is row 0 of a new block.
- R7: in_ready is high exactly when the output register is empty or is being drained in the same cycle. A row held under backpressure stays stable until it is accepted.
- R8: A synchronous reset clears out_valid, restarts the row count at 0 and clears the previous block, including when it arrives in the middle of a block.
- R9: A row accepted on a clock edge appears on out_row with out_valid high right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Information beat offered |
| in_ready | output | 1 | Encoder can take a beat |
| in_info | input | K (3) | Information bits of one row |
| out_valid | output | 1 | Coded row available |
| out_ready | input | 1 | Sink takes the coded row |
| out_row | output | S (8) | Coded row: info, check bits, overall parity |

## Verification
The coupling store cannot be seen directly. A wrong entry in it appears in the check bits of the row with that column index in the next block, which is at most 2S accepted beats after the fault. A row counter that is off shows up immediately as the wrong column being used, or one block later as a late commit. The bench keeps its own copy of every emitted block and predicts each row exactly. This exposes a bad column, stale storage after reset, or a corrupted held row on the first beat where the values differ.

// File: rtl/sc_enc_pkg.sv
package sc_enc_pkg;

    // Hamming position of data bit n: n-th integer >= 1 that is not a power of two
    function automatic int data_pos(input int n);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p < 4096; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == n && res == 0) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/sc_hamming_parity.sv
module sc_hamming_parity #(
    parameter int D = 11,
    parameter int M = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [D-1:0] data,
    output logic [M-1:0] chk,
    output logic         ovr
);
    import sc_enc_pkg::*;

    localparam int N = 2 ** M;

    always_comb begin
        int p;
        chk = '0;
        for (int n = 0; n < D; n++) begin
            p = data_pos(n);
            for (int k = 0; k < M; k++) begin
                if (p[k]) chk[k] = chk[k] ^ data[n];
            end
        end
        ovr = (^data) ^ (^chk);
    end

    // codeword rebuilt by position, checked by syndrome (R3)
    logic [N-1:0] cw;
    logic [M-1:0] syn;

    always_comb begin
        cw = '0;
        cw[0] = ovr;
        for (int k = 0; k < M; k++) cw[2 ** k] = chk[k];
        for (int n = 0; n < D; n++) cw[data_pos(n)] = data[n];
        syn = '0;
        for (int i = 1; i < N; i++) begin
            if (cw[i]) syn = syn ^ M'(i);
        end
    end

    a_r3_codeword_valid: assert property (@(posedge clk) disable iff (rst)
        (syn == '0) && ((^cw) == 1'b0))
        else $error("R3: codeword syndrome %0h", syn);

endmodule

// File: rtl/sc_block_store.sv
module sc_block_store #(
    parameter int S  = 8,
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_last,
    input  logic [RW-1:0] wr_idx,
    input  logic [S-1:0]  wr_row,
    input  logic [RW-1:0] col_idx,
    output logic [S-1:0]  col
);
    typedef struct packed {
        logic [S-1:0][S-1:0] prev;
        logic [S-1:0][S-1:0] cur;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cur[wr_idx] = wr_row;
            if (wr_last) begin
                st_d.prev = st_q.cur;
                st_d.prev[wr_idx] = wr_row;
            end
        end
        for (int r = 0; r < S; r++) col[r] = st_q.prev[r][col_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    a_r6_block_commit: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_last) |=> (st_q.prev[S-1] == $past(wr_row)))
        else $error("R6: last row not committed");

endmodule

// File: rtl/sc_staircase_encoder.sv
module sc_staircase_encoder #(
    parameter int S = 8,
    parameter int M = $clog2(2 * S),
    parameter int K = S - M - 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [K-1:0] in_info,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [S-1:0] out_row
);
    localparam int RW = $clog2(S);
    localparam int D  = S + K;

    typedef struct packed {
        logic [RW-1:0] row;
        logic          vld;
        logic [S-1:0]  data;
    } enc_t;

    enc_t e_d, e_q;

    logic         accept;
    logic         last;
    logic [S-1:0] col;
    logic [M-1:0] chk;
    logic         ovr;
    logic [S-1:0] new_row;

    sc_block_store #(.S(S), .RW(RW)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (accept),
        .wr_last(last),
        .wr_idx (e_q.row),
        .wr_row (new_row),
        .col_idx(e_q.row),
        .col    (col)
    );

    sc_hamming_parity #(.D(D), .M(M)) u_par (
        .clk (clk),
        .rst (rst),
        .data({in_info, col}),
        .chk (chk),
        .ovr (ovr)
    );

    always_comb begin
        in_ready = !e_q.vld || out_ready;
        accept   = in_valid && in_ready;
        last     = (e_q.row == RW'(S - 1));
        new_row  = {ovr, chk, in_info};

        e_d = e_q;
        if (accept) begin
            e_d.vld  = 1'b1;
            e_d.data = new_row;
            e_d.row  = last ? '0 : e_q.row + 1'b1;
        end else if (out_ready) begin
            e_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) e_q <= '0;
        else     e_q <= e_d;
    end

    assign out_valid = e_q.vld;
    assign out_row   = e_q.data;

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row)))
        else $error("R7: held row changed");

    a_r7_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready)
        else $error("R7: ready while stalled");

    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && out_row[K-1:0] == $past(in_info)))
        else $error("R9: accepted row missing");

    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        (accept && last) |=> (e_q.row == '0))
        else $error("R6: row count did not wrap");

endmodule

// File: tb/sc_staircase_encoder_bench.sv
module sc_staircase_encoder_bench;
    localparam int S = 8;
    localparam int M = 4;
    localparam int K = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [K-1:0] in_info = '0;
    logic out_ready = 1'b1;
    logic in_ready, out_valid;
    logic [S-1:0] out_row;

    int checks = 0;
    int errors = 0;

    logic [S-1:0] prev_m [S];
    logic [S-1:0] cur_m  [S];
    int row_m = 0;

    always #2.5 clk = ~clk;

    sc_staircase_encoder u_sc_staircase_encoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_info(in_info), .out_valid(out_valid), .out_ready(out_ready),
        .out_row(out_row)
    );

    function automatic int hpos(input int n);
        int c = 0;
        int r = 0;
        for (int p = 1; p < 64; p++) begin
            if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32) begin
                if (c == n && r == 0) r = p;
                c++;
            end
        end
        return r;
    endfunction

    // expected coded row per R1, R2, R3
    function automatic logic [S-1:0] model_row(input int j, input logic [K-1:0] info);
        logic [S+K-1:0] d;
        logic [M-1:0] c;
        logic o;
        int p;
        for (int r = 0; r < S; r++) d[r] = prev_m[r][j];
        for (int b = 0; b < K; b++) d[S+b] = info[b];
        c = '0;
        for (int n = 0; n < S + K; n++) begin
            p = hpos(n);
            for (int k = 0; k < M; k++) if (((p >> k) & 1) == 1) c[k] = c[k] ^ d[n];
        end
        o = (^d) ^ (^c);
        return {o, c, info};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int r = 0; r < S; r++) begin
            prev_m[r] = '0;
            cur_m[r]  = '0;
        end
        row_m = 0;
    endtask

    task automatic commit_model(input logic [S-1:0] row);
        cur_m[row_m] = row;
        if (row_m == S - 1) begin
            for (int r = 0; r < S; r++) prev_m[r] = cur_m[r];
            row_m = 0;
        end else begin
            row_m++;
        end
    endtask

    // one beat with out_ready high; checks row the cycle after acceptance
    task automatic send(input logic [K-1:0] info, input string req);
        logic [S-1:0] e;
        e = model_row(row_m, info);
        @(negedge clk);
        in_valid = 1'b1;
        in_info  = info;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {31'b0, out_valid}, 32'd1);
        check(req, {24'b0, out_row}, {24'b0, e});
        commit_model(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        clear_model();
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R8 out_valid", {31'b0, out_valid}, 32'd0);
        check("R7 in_ready", {31'b0, in_ready}, 32'd1);
    endtask

    task automatic t_first_block();
        // R4: previous block zero; R1 layout visible with info 3'b101
        for (int j = 0; j < S; j++) send(K'(j * 5 + 1), "R4 first block");
    endtask

    task automatic t_coupled_blocks();
        // R5, R6: columns of stored block feed next block
        for (int b = 0; b < 3; b++)
            for (int j = 0; j < S; j++) send(K'(j ^ (b * 3)), "R5 coupled row");
        for (int j = 0; j < S; j++) send('1, "R2 all ones info");
    endtask

    task automatic t_backpressure();
        logic [S-1:0] ea, eb;
        @(negedge clk);
        out_ready = 1'b0;
        ea = model_row(row_m, 3'b110);
        in_valid = 1'b1;
        in_info  = 3'b110;
        @(negedge clk);
        commit_model(ea);
        eb = model_row(row_m, 3'b011);
        in_info = 3'b011;
        check("R7 stall ready low", {31'b0, in_ready}, 32'd0);
        check("R9 row A", {24'b0, out_row}, {24'b0, ea});
        @(negedge clk);
        check("R7 held stable", {24'b0, out_row}, {24'b0, ea});
        check("R7 held valid", {31'b0, out_valid}, 32'd1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 row B after release", {24'b0, out_row}, {24'b0, eb});
        commit_model(eb);
        @(negedge clk);
        check("R7 drained", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_mid_reset();
        for (int j = 0; j < 3; j++) send(K'(j + 2), "R8 pre-reset");
        do_reset();
        check("R8 cleared valid", {31'b0, out_valid}, 32'd0);
        for (int j = 0; j < S; j++) send(K'(7 - j), "R8 restart zero store");
        for (int j = 0; j < S; j++) send(K'(j), "R6 after restart");
    endtask

    initial begin
        clear_model();
        t_reset_state();
        t_first_block();
        t_coupled_blocks();
        t_backpressure();
        for (int j = row_m; j < S; j++) send(3'b010, "R6 finish block");
        for (int j = 0; j < S; j++) send(K'(j + 3), "R5 after stall");
        t_mid_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule